// File: doc/BRIEF.md
# Dual-Channel Cycle-Stepped DMA Arbiter

This block masters the bus of an 8-bit processor system on behalf of two DMA channels and advances by one step on every processor cycle. The page channel copies a whole 256-byte page of memory, one byte at a time, into a fixed data-port address. Each byte costs a read cycle and then a write cycle. The sample channel fetches a single byte for an audio unit. It ranks above the page channel and may cut into a page copy that is already running. The frozen copy then resumes where it stopped.

On every cycle the block presents one bus action with an address and, for port writes, a data byte. It also drives a halt line to the processor, a busy flag per channel and a counter of the cycles the transfers have used. Both channels add alignment cycles based on the parity of the global processor cycle count, which the system supplies as `cyc_odd`. Requests are single-cycle strobes with no back-pressure: the block never refuses a page request. The read data bus must carry the addressed byte in the same cycle as the page read, because it is captured at the clock edge that ends that cycle.

Top module: `dma_arbiter`

## Requirements
- R1: Reset puts both channels in the idle state, clears the cycle counter and drives action code 0 (none), address 0, data 0 and a low halt line. This also holds when reset arrives in the middle of a transfer.
- R2: Action codes are 0 none, 1 dummy read, 2 page read, 3 port write and 4 sample read. A page request first gives one dummy read of address 0. If `cyc_odd` was high in the request cycle, a second dummy read of address 0 follows before the first byte.
- R3: Each copied byte is a page read at address {page, offset}, followed by a port write to 0x2004. The port write carries the byte that was on `rd_data` during that page read.
- R4: The offset starts at 0 and rises by one after each port write. After the write at offset 0xFF the page channel goes idle, so exactly 256 port writes occur per copy.
- R5: A sample request that arrives while the sample channel is busy is ignored. The running sequence keeps its original halted address.
- R6: A sample request goes through these cycles in order: a dummy read of the halted address; a second cycle that is a dummy read of that address if `cyc_odd` is high, or otherwise a sample read at address 0; one more sample read if the second cycle was a dummy; and a final cycle with action none, after which the channel is idle.
- R7: While the sample channel is busy it owns the bus. No page read or port write is issued, and the page channel keeps its position until the sample channel is idle again.
- R8: The counter rises by one on every cycle in which either channel is busy. A page request clears it to 0. A take strobe clears it, keeping 1 if the take cycle itself was busy.
- R9: `pg_busy` and `smp_busy` show when each channel is not idle, and `cpu_halt` is their OR. With both channels idle the action is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_odd | input | 1 | Parity of the global processor cycle count, 1 = odd |
| pg_start | input | 1 | Page-copy request strobe |
| pg_start_page | input | 8 | Source page of the copy |
| smp_start | input | 1 | Sample fetch request strobe |
| smp_start_addr | input | 16 | Address the processor was reading when halted |
| rd_data | input | 8 | Read data returned by memory in the current cycle |
| cnt_take | input | 1 | Clear strobe for the cycle counter |
| act | output | 3 | Bus action code of this cycle |
| act_addr | output | 16 | Bus address of this cycle |
| act_wdata | output | 8 | Data for a port write, 0 otherwise |
| cpu_halt | output | 1 | Processor halt, high while any channel is busy |
| pg_busy | output | 1 | Page channel not idle |
| smp_busy | output | 1 | Sample channel not idle |
| cnt_value | output | 16 | Cycles used since the last clear |

## Verification
A request sampled at one clock edge shows its first bus action in the following cycle. The counter and busy flags also move one edge after the cycle they account for. A page-read byte appears on `act_wdata` in the next cycle in which the page channel owns the bus. The bench drives stimulus and compares outputs 1 ns after each falling edge. It advances a cycle-level reference model once per edge, so each expected value is compared in the cycle it is due, including across sample pre-emptions and parity-dependent alignment cycles.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_DUMMY  = 3'd1,
    ACT_PREAD  = 3'd2,
    ACT_PWRITE = 3'd3,
    ACT_SREAD  = 3'd4
  } act_e;

  typedef enum logic [2:0] {
    P_IDLE, P_PEND, P_ALIGN, P_READ, P_WRITE
  } pg_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HALT, S_DUMMY, S_ALIGN, S_DONE
  } smp_st_e;
endpackage

// File: rtl/dma_page_chan.sv
module dma_page_chan
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic              cyc_odd,
  input  logic              hold,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output act_e              act,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam int OFF_W = ADDR_W - PAGE_W;

  pg_st_e             state;
  logic [PAGE_W-1:0]  page;
  logic [OFF_W-1:0]   off;
  logic               need_align;
  logic [DATA_W-1:0]  val;
  logic               adv;

  assign busy = (state != P_IDLE);
  assign adv  = busy && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= P_IDLE;
      page       <= '0;
      off        <= '0;
      need_align <= 1'b0;
      val        <= '0;
    end else if (start) begin
      state      <= P_PEND;
      page       <= start_page;
      off        <= '0;
      need_align <= cyc_odd;
    end else if (adv) begin
      case (state)
        P_PEND:  state <= need_align ? P_ALIGN : P_READ;
        P_ALIGN: state <= P_READ;
        P_READ: begin
          val   <= rd_data;
          state <= P_WRITE;
        end
        P_WRITE: begin
          off   <= off + 1'b1;
          state <= (&off) ? P_IDLE : P_READ;
        end
        default: state <= P_IDLE;
      endcase
    end
  end

  always_comb begin
    act   = ACT_NONE;
    addr  = '0;
    wdata = '0;
    case (state)
      P_PEND, P_ALIGN: act = ACT_DUMMY;
      P_READ: begin
        act  = ACT_PREAD;
        addr = {page, off};
      end
      P_WRITE: begin
        act   = ACT_PWRITE;
        addr  = PORT_ADDR;
        wdata = val;
      end
      default: act = ACT_NONE;
    endcase
  end

  AST_LAST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_WRITE && adv && (&off) && !start) |=> (state == P_IDLE)) else $error("last write"); // R4
  AST_WRITE_CARRIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_WRITE && $past(state) == P_READ) |-> (wdata == $past(rd_data))) else $error("write data"); // R3
endmodule

// File: rtl/dma_smp_chan.sv
module dma_smp_chan
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              cyc_odd,
  output logic              busy,
  output act_e              act,
  output logic [ADDR_W-1:0] addr
);
  smp_st_e            state;
  logic [ADDR_W-1:0]  haddr;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      haddr <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_HALT;
          haddr <= start_addr;
        end
        S_HALT:  state <= S_DUMMY;
        S_DUMMY: state <= cyc_odd ? S_ALIGN : S_DONE;
        S_ALIGN: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    act  = ACT_NONE;
    addr = '0;
    case (state)
      S_HALT: begin
        act  = ACT_DUMMY;
        addr = haddr;
      end
      S_DUMMY: begin
        act  = cyc_odd ? ACT_DUMMY : ACT_SREAD;
        addr = cyc_odd ? haddr : '0;
      end
      S_ALIGN: act = ACT_SREAD;
      default: act = ACT_NONE;
    endcase
  end

  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (haddr == $past(haddr))) else $error("busy request taken"); // R5
endmodule

// File: rtl/dma_cycle_cnt.sv
module dma_cycle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             active,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clr)     count <= '0;
    else if (take)    count <= {{(CNT_W-1){1'b0}}, active};
    else if (active)  count <= count + 1'b1;
  end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_odd,
  input  logic              pg_start,
  input  logic [PAGE_W-1:0] pg_start_page,
  input  logic              smp_start,
  input  logic [ADDR_W-1:0] smp_start_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cnt_take,
  output logic [2:0]        act,
  output logic [ADDR_W-1:0] act_addr,
  output logic [DATA_W-1:0] act_wdata,
  output logic              cpu_halt,
  output logic              pg_busy,
  output logic              smp_busy,
  output logic [CNT_W-1:0]  cnt_value
);
  act_e              pg_act, smp_act, sel_act;
  logic [ADDR_W-1:0] pg_addr, smp_addr;
  logic [DATA_W-1:0] pg_wdata;

  dma_page_chan #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)
  ) u_page (
    .clk(clk), .rst_n(rst_n), .start(pg_start), .start_page(pg_start_page),
    .cyc_odd(cyc_odd), .hold(smp_busy), .rd_data(rd_data),
    .busy(pg_busy), .act(pg_act), .addr(pg_addr), .wdata(pg_wdata)
  );

  dma_smp_chan #(.ADDR_W(ADDR_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .start(smp_start), .start_addr(smp_start_addr),
    .cyc_odd(cyc_odd), .busy(smp_busy), .act(smp_act), .addr(smp_addr)
  );

  assign cpu_halt = pg_busy | smp_busy;

  dma_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pg_start), .take(cnt_take),
    .active(cpu_halt), .count(cnt_value)
  );

  always_comb begin
    sel_act   = ACT_NONE;
    act_addr  = '0;
    act_wdata = '0;
    if (smp_busy) begin
      sel_act  = smp_act;
      act_addr = smp_addr;
    end else if (pg_busy) begin
      sel_act   = pg_act;
      act_addr  = pg_addr;
      act_wdata = pg_wdata;
    end
  end

  assign act = sel_act;

  AST_SAMPLE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_busy |-> (act != ACT_PREAD && act != ACT_PWRITE)) else $error("page access during sample"); // R7
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt |-> (act == ACT_NONE && act_addr == '0)) else $error("idle bus action"); // R9
  AST_SREAD_AFTER_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SREAD) |-> ($past(act) == ACT_DUMMY)) else $error("sample read order"); // R6
  AST_COUNT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && !cnt_take && !pg_start) |=> (cnt_value != '0)) else $error("counter stuck"); // R8
endmodule

// File: tb/dma_arbiter_bench.sv
module dma_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_odd = 1'b0;
  logic pg_start = 1'b0;
  logic [7:0] pg_start_page = '0;
  logic smp_start = 1'b0;
  logic [15:0] smp_start_addr = '0;
  logic [7:0] rd_data = '0;
  logic cnt_take = 1'b0;
  logic [2:0] act;
  logic [15:0] act_addr;
  logic [7:0] act_wdata;
  logic cpu_halt, pg_busy, smp_busy;
  logic [15:0] cnt_value;

  always #2.5 clk = ~clk;

  dma_arbiter u_dma_arbiter (
    .clk(clk), .rst_n(rst_n), .cyc_odd(cyc_odd), .pg_start(pg_start),
    .pg_start_page(pg_start_page), .smp_start(smp_start),
    .smp_start_addr(smp_start_addr), .rd_data(rd_data), .cnt_take(cnt_take),
    .act(act), .act_addr(act_addr), .act_wdata(act_wdata), .cpu_halt(cpu_halt),
    .pg_busy(pg_busy), .smp_busy(smp_busy), .cnt_value(cnt_value)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int unsigned gcyc = 0;

  // reference model state
  int m_pst = 0;           // 0 idle 1 pend 2 align 3 read 4 write
  int m_sst = 0;           // 0 idle 1 halt 2 dummy 3 align 4 done
  logic [7:0] m_pg = 0, m_off = 0, m_val = 0;
  bit m_odd = 0;
  logic [15:0] m_haddr = 0, m_cnt = 0;
  bit ign = 0;
  int dut_wr = 0;
  bit prev_pg_busy = 0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd29;
    return p ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, gcyc);
    end
  endtask

  task automatic model_reset();
    m_pst = 0; m_sst = 0; m_cnt = 0; m_off = 0; m_val = 0; ign = 0;
  endtask

  task automatic cyc(input bit preq, input logic [7:0] ppage, input bit sreq,
                     input logic [15:0] saddr, input bit tk);
    logic [2:0] e_act;
    logic [15:0] e_addr;
    logic [7:0] e_wd;
    string tag;
    bit active, par;
    par = gcyc[0];
    cyc_odd = par;
    pg_start = preq; pg_start_page = ppage;
    smp_start = sreq; smp_start_addr = saddr;
    cnt_take = tk;
    e_act = 0; e_addr = 0; e_wd = 0;
    if (m_sst != 0) begin
      tag = ign ? "R5" : (m_pst != 0 ? "R7" : "R6");
      case (m_sst)
        1: begin e_act = 1; e_addr = m_haddr; end
        2: begin e_act = par ? 3'd1 : 3'd4; e_addr = par ? m_haddr : 16'h0; end
        3: e_act = 4;
        default: e_act = 0;
      endcase
    end else if (m_pst != 0) begin
      tag = (m_pst <= 2) ? "R2" : "R3";
      case (m_pst)
        1, 2: e_act = 1;
        3: begin e_act = 2; e_addr = {m_pg, m_off}; end
        default: begin e_act = 3; e_addr = 16'h2004; e_wd = m_val; end
      endcase
    end else tag = "R9";
    rd_data = (e_act == 2) ? mem(e_addr) : 8'($urandom);
    #1;
    chk(act == e_act, {tag, " action"}, act, e_act);
    chk(act_addr == e_addr, {tag, " address"}, act_addr, e_addr);
    chk(act_wdata == e_wd, {tag, " wdata"}, act_wdata, e_wd);
    chk(pg_busy == (m_pst != 0), "R9 pg_busy", pg_busy, m_pst != 0);
    chk(smp_busy == (m_sst != 0), "R9 smp_busy", smp_busy, m_sst != 0);
    chk(cpu_halt == (m_pst != 0 || m_sst != 0), "R9 cpu_halt", cpu_halt, 0);
    chk(cnt_value == m_cnt, "R8 counter", cnt_value, m_cnt);
    if (act == 3) dut_wr++;
    if (prev_pg_busy && !pg_busy)
      chk(dut_wr == 256, "R4 writes per copy", dut_wr, 256);
    prev_pg_busy = pg_busy;
    if (preq) dut_wr = 0;
    // model next state
    active = (m_pst != 0) || (m_sst != 0);
    if (preq) m_cnt = 0;
    else if (tk) m_cnt = active ? 16'd1 : 16'd0;
    else if (active) m_cnt = m_cnt + 1;
    if (m_sst == 0 && m_pst != 0) begin
      case (m_pst)
        1: m_pst = m_odd ? 2 : 3;
        2: m_pst = 3;
        3: begin m_val = mem({m_pg, m_off}); m_pst = 4; end
        default: begin m_pst = (m_off == 8'hFF) ? 0 : 3; m_off = m_off + 1; end
      endcase
    end
    if (m_sst != 0) begin
      if (sreq) ign = 1;
      case (m_sst)
        1: m_sst = 2;
        2: m_sst = par ? 3 : 4;
        3: m_sst = 4;
        default: begin m_sst = 0; ign = 0; end
      endcase
    end else if (sreq) begin
      m_sst = 1; m_haddr = saddr;
    end
    if (preq) begin
      m_pst = 1; m_pg = ppage; m_off = 0; m_odd = par;
    end
    @(negedge clk);
    gcyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 700 && (m_pst != 0 || m_sst != 0); i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic reset_phase();
    rst_n = 0;
    pg_start = 0; smp_start = 0; cnt_take = 0;
    repeat (2) begin @(negedge clk); gcyc++; end
    #1;
    chk(act == 0, "R1 action", act, 0);
    chk(act_addr == 0 && act_wdata == 0, "R1 bus", act_addr, 0);
    chk(!cpu_halt && !pg_busy && !smp_busy, "R1 busy", {pg_busy, smp_busy}, 0);
    chk(cnt_value == 0, "R1 counter", cnt_value, 0);
    model_reset();
    prev_pg_busy = 0;
    rst_n = 1;
    @(negedge clk); gcyc++;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    reset_phase();
    idle(3);
    // page copy requested on an even cycle
    if (gcyc[0]) idle(1);
    cyc(1, 8'h3C, 0, 0, 0);
    drain();
    cyc(0, 0, 0, 0, 1);                       // R8 take
    idle(2);
    // page copy requested on an odd cycle (extra alignment) R2
    if (!gcyc[0]) idle(1);
    cyc(1, 8'hC1, 0, 0, 0);
    drain();
    // lone sample requests on both parities R6
    cyc(0, 0, 1, 16'h8123, 0); drain();
    idle(1);
    cyc(0, 0, 1, 16'hC0DE, 0); drain();
    // pre-emption with an ignored second request R7 R5
    for (int k = 0; k < 4; k++) begin
      cyc(1, 8'(k * 37 + 5), 0, 0, 0);
      idle(3 + int'($urandom_range(0, 300)));
      cyc(0, 0, 1, 16'(32'hF000 + k), 0);
      cyc(0, 0, 1, 16'h1111, 0);
      idle(int'($urandom_range(0, 2)));
      cyc(0, 0, 1, 16'h2222, 0);
      drain();
    end
    // reset during a copy R1
    cyc(1, 8'h77, 0, 0, 0);
    idle(40);
    reset_phase();
    idle(2);
    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      bit p, s, t;
      p = (m_pst == 0) && ($urandom_range(0, 49) == 0);
      s = ($urandom_range(0, 29) == 0);
      t = ($urandom_range(0, 79) == 0);
      cyc(p, 8'($urandom), s, 16'($urandom), t);
    end
    drain();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule